// File: doc/BRIEF.md
# Video Packet Filter with Time-Shared Output Bus

This block watches a byte-wide transport stream and keeps only the packets whose 13-bit packet identifier equals a programmable value. It walks each kept packet past its header and any adaptation field and hands the payload to an output queue. A mode input picks one of two outputs. In the first, every payload byte of the PES stream goes out. In the second, the PES header at the start of each payload unit is removed, so only the bare elementary stream goes out. While the header passes, the block pulls out the presentation timestamp and, when present, the decoding timestamp. It keeps them in registers that a host controller can read. A flag stays raised until the host acknowledges the new pair.

Bytes leave over an 8-bit bus, at most one byte every `DIV` clocks (9 MHz from a 27 MHz clock by default). A host select input decides who owns the bus. While select is low, the block drives nothing and sends no bytes, so the host can use the wires to talk to the decoder. The bus pads are tri-stated by an output-enable that follows select one cycle late. When select comes back, the output resumes with the byte that was next in line.

Top module: `vid_pes_filter`

## Requirements
- R1: A packet carries payload for this block only when its 13-bit identifier ({byte1[4:0], byte2}) equals `cfg_pid`. Packets with any other identifier produce no output bytes and leave the timestamp registers and flag unchanged.
- R2: Packet byte 3 bits [5:4] give the adaptation mode. 01 means the payload starts at byte 4. 11 means byte 4 is a length L, and the payload starts at byte 5+L. 10 and 00 mean the packet has no payload.
- R3: With `cfg_es`=0, every payload byte of a selected packet is output, in arrival order.
- R4: With `cfg_es`=1, in a packet whose payload-unit-start bit (byte1[6]) is set, the first 9+H payload bytes are dropped. H is payload byte 8. Payload of packets without the start bit is output in full.
- R5: In a start packet, the flags at payload byte 7 bits [7:6] select what is captured. When the flags are 10, the 33-bit presentation timestamp is assembled from payload bytes 9..13 as {b9[3:1], b10, b11[7:1], b12, b13[7:1]}, with the marker bits skipped. It is published with `stamp_has_dts`=0.
- R6: When the flags are 11, the decoding timestamp is taken from payload bytes 14..18 in the same layout. Both stamps are published together in one cycle, with `stamp_has_dts`=1.
- R7: `stamp_new` rises in the cycle after a publish. It falls only in the cycle after `stamp_ack` is sampled high with no publish at that edge; a publish wins over an acknowledge.
- R8: `vid_valid` pulses are at least `DIV` cycles apart.
- R9: No byte is output in the cycle after `host_sel` is sampled low. When select returns high, output resumes at the next unsent byte, with none lost or repeated.
- R10: `vid_oe` equals the value of `host_sel` at the previous clock edge, and `vid_valid` is high only while `vid_oe` is high.
- R11: While reset is held, `vid_oe`, `vid_valid` and `stamp_new` are 0 and both timestamp registers read 0.
- R12: `ts_sync` high with a valid byte marks byte 0 of a packet and restarts header parsing, even if the previous packet was cut short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (27 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| ts_data | input | 8 | Transport stream byte |
| ts_valid | input | 1 | `ts_data` holds a byte this cycle |
| ts_sync | input | 1 | Current byte is packet byte 0 |
| cfg_pid | input | 13 | Identifier of the packets to keep |
| cfg_es | input | 1 | 0: PES stream out, 1: elementary stream out |
| host_sel | input | 1 | 1: block owns the output bus, 0: host owns it |
| stamp_ack | input | 1 | Host has read the timestamps |
| vid_data | output | 8 | Output byte for the bus pads |
| vid_valid | output | 1 | `vid_data` carries a new byte |
| vid_oe | output | 1 | Output enable for the bus pads |
| pts_val | output | 33 | Last published presentation timestamp |
| dts_val | output | 33 | Last published decoding timestamp |
| stamp_has_dts | output | 1 | Last publish included a decoding timestamp |
| stamp_new | output | 1 | Unacknowledged timestamps are waiting |

## Verification
The properties assume that `host_sel` and `stamp_ack` change only between clock edges. They also assume the input byte rate is low enough that the internal queue never overflows, even across the longest select-low window, because a dropped byte would show up as lost data rather than as a property failure. The stimulus presents one byte every five clocks. It holds select low for 17 of every 60 cycles, which keeps the average drain rate above the fill rate. All packets are well formed, and every PES header is long enough to hold the timestamps that its flags announce.

// File: rtl/vpf_pkg.sv
package vpf_pkg;

  typedef enum logic [2:0] {
    SEG_HDR,
    SEG_AFLEN,
    SEG_AFSKIP,
    SEG_PAYLOAD,
    SEG_IDLE
  } seg_e;

  localparam logic [7:0] HDR_LAST_IDX = 8'd3;
  localparam logic [7:0] PES_FLAG_OFF = 8'd7;
  localparam logic [7:0] PES_HLEN_OFF = 8'd8;
  localparam logic [7:0] PES_FIXED    = 8'd9;
  localparam logic [7:0] PTS_OFF      = 8'd9;
  localparam logic [7:0] DTS_OFF      = 8'd14;
  localparam logic [7:0] STAMP_BYTES  = 8'd5;

  typedef logic [32:0] stamp_t;

endpackage

// File: rtl/vpf_parse.sv
module vpf_parse
  import vpf_pkg::*;
#(
  parameter int PID_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       ts_data,
  input  logic             ts_valid,
  input  logic             ts_sync,
  input  logic [PID_W-1:0] cfg_pid,
  input  logic             cfg_es,
  output logic             push,
  output logic [7:0]       push_data,
  output logic             pes_vld,
  output logic [7:0]       pes_off
);

  logic [7:0] cnt_q, cnt_d;
  seg_e       seg_q, seg_d, seg_cur;
  logic       pusi_q, pusi_d;
  logic [4:0] pidhi_q, pidhi_d;
  logic       match_q, match_d;
  logic [7:0] skip_q, skip_d;
  logic [7:0] off_q, off_d;
  logic [7:0] hlen_q, hlen_d;
  logic [7:0] idx;
  logic       in_pl, in_hdr;

  assign idx     = ts_sync ? 8'd0 : cnt_q;
  assign seg_cur = ts_sync ? SEG_HDR : seg_q;
  assign in_pl   = ts_valid && (seg_cur == SEG_PAYLOAD) && match_q;
  assign pes_vld = in_pl && pusi_q;
  assign pes_off = off_q;
  assign in_hdr  = pes_vld && ((off_q < PES_FIXED) || ((off_q - PES_FIXED) < hlen_q));

  assign push      = in_pl && !(cfg_es && in_hdr);
  assign push_data = ts_data;

  always_comb begin
    cnt_d   = cnt_q;
    seg_d   = seg_q;
    pusi_d  = pusi_q;
    pidhi_d = pidhi_q;
    match_d = match_q;
    skip_d  = skip_q;
    off_d   = off_q;
    hlen_d  = hlen_q;
    if (ts_valid) begin
      cnt_d = (idx == 8'hFF) ? idx : idx + 8'd1;
      seg_d = seg_cur;
      if (idx == 8'd1) begin
        pusi_d  = ts_data[6];
        pidhi_d = ts_data[4:0];
      end
      if (idx == 8'd2) begin
        match_d = ({pidhi_q, ts_data} == cfg_pid);
      end
      case (seg_cur)
        SEG_HDR: begin
          if (idx == HDR_LAST_IDX) begin
            off_d = 8'd0;
            case (ts_data[5:4])
              2'b01:   seg_d = SEG_PAYLOAD;
              2'b11:   seg_d = SEG_AFLEN;
              default: seg_d = SEG_IDLE;
            endcase
          end
        end
        SEG_AFLEN: begin
          skip_d = ts_data;
          seg_d  = (ts_data == 8'd0) ? SEG_PAYLOAD : SEG_AFSKIP;
        end
        SEG_AFSKIP: begin
          skip_d = skip_q - 8'd1;
          if (skip_q == 8'd1) seg_d = SEG_PAYLOAD;
        end
        SEG_PAYLOAD: begin
          if (off_q != 8'hFF) off_d = off_q + 8'd1;
          if (pusi_q && (off_q == PES_HLEN_OFF)) hlen_d = ts_data;
        end
        default: seg_d = SEG_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= 8'd0;
      seg_q   <= SEG_IDLE;
      pusi_q  <= 1'b0;
      pidhi_q <= 5'd0;
      match_q <= 1'b0;
      skip_q  <= 8'd0;
      off_q   <= 8'd0;
      hlen_q  <= 8'd0;
    end else if (ts_valid) begin
      cnt_q   <= cnt_d;
      seg_q   <= seg_d;
      pusi_q  <= pusi_d;
      pidhi_q <= pidhi_d;
      match_q <= match_d;
      skip_q  <= skip_d;
      off_q   <= off_d;
      hlen_q  <= hlen_d;
    end
  end

endmodule

// File: rtl/vpf_stamp.sv
module vpf_stamp
  import vpf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pes_vld,
  input  logic [7:0] pes_off,
  input  logic [7:0] pes_data,
  input  logic       ack,
  output stamp_t     pts,
  output stamp_t     dts,
  output logic       has_dts,
  output logic       fresh
);

  logic [1:0]  flags_q, flags_d;
  logic [32:7] acc_q, acc_d;
  stamp_t      tmp_q, tmp_d;
  stamp_t      pts_q, pts_d;
  stamp_t      dts_q, dts_d;
  logic        has_q, has_d;
  logic        new_q, new_d;
  logic        in_pts, in_dts, publish;
  logic [7:0]  rel;
  stamp_t      assembled;

  assign in_pts    = (pes_off >= PTS_OFF) && (pes_off < PTS_OFF + STAMP_BYTES);
  assign in_dts    = (pes_off >= DTS_OFF) && (pes_off < DTS_OFF + STAMP_BYTES);
  assign rel       = in_pts ? (pes_off - PTS_OFF) : (pes_off - DTS_OFF);
  assign assembled = {acc_q, pes_data[7:1]};

  always_comb begin
    flags_d = flags_q;
    acc_d   = acc_q;
    tmp_d   = tmp_q;
    pts_d   = pts_q;
    dts_d   = dts_q;
    has_d   = has_q;
    publish = 1'b0;
    if (pes_vld) begin
      if (pes_off == PES_FLAG_OFF) flags_d = pes_data[7:6];
      if (in_pts || in_dts) begin
        case (rel)
          8'd0:    acc_d[32:30] = pes_data[3:1];
          8'd1:    acc_d[29:22] = pes_data;
          8'd2:    acc_d[21:15] = pes_data[7:1];
          8'd3:    acc_d[14:7]  = pes_data;
          default: acc_d        = acc_q;
        endcase
      end
      if (in_pts && (rel == STAMP_BYTES - 8'd1) && flags_q[1]) begin
        tmp_d = assembled;
        if (flags_q == 2'b10) begin
          pts_d   = assembled;
          has_d   = 1'b0;
          publish = 1'b1;
        end
      end
      if (in_dts && (rel == STAMP_BYTES - 8'd1) && (flags_q == 2'b11)) begin
        pts_d   = tmp_q;
        dts_d   = assembled;
        has_d   = 1'b1;
        publish = 1'b1;
      end
    end
    new_d = publish ? 1'b1 : (ack ? 1'b0 : new_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= 2'b00;
      acc_q   <= '0;
      tmp_q   <= '0;
      pts_q   <= '0;
      dts_q   <= '0;
      has_q   <= 1'b0;
      new_q   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      acc_q   <= acc_d;
      tmp_q   <= tmp_d;
      pts_q   <= pts_d;
      dts_q   <= dts_d;
      has_q   <= has_d;
      new_q   <= new_d;
    end
  end

  assign pts     = pts_q;
  assign dts     = dts_q;
  assign has_dts = has_q;
  assign fresh   = new_q;

endmodule

// File: rtl/vpf_fifo.sv
module vpf_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full
);

  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp_q, wp_d, rp_q, rp_d;
  logic         do_wr, do_rd;

  assign empty   = (wp_q == rp_q);
  assign full    = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
  assign do_wr   = wr_en && !full;
  assign do_rd   = rd_en && !empty;
  assign rd_data = mem[rp_q[AW-1:0]];
  assign wp_d    = do_wr ? wp_q + 1'b1 : wp_q;
  assign rp_d    = do_rd ? rp_q + 1'b1 : rp_q;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp_q[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      wp_q <= wp_d;
      rp_q <= rp_d;
    end
  end

endmodule

// File: rtl/vpf_drive.sv
module vpf_drive #(
  parameter int DIV = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_sel,
  input  logic       q_empty,
  input  logic [7:0] q_data,
  output logic       pop,
  output logic [7:0] vid_data,
  output logic       vid_valid,
  output logic       vid_oe
);

  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] PACE_LAST = PW'(DIV - 1);

  logic [PW-1:0] pace_q, pace_d;
  logic          tick;
  logic          oe_q;
  logic          valid_q;
  logic [7:0]    data_q, data_d;

  assign tick   = (pace_q == PACE_LAST);
  assign pace_d = tick ? '0 : pace_q + 1'b1;
  assign pop    = tick && host_sel && oe_q && !q_empty;
  assign data_d = pop ? q_data : data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pace_q  <= '0;
      oe_q    <= 1'b0;
      valid_q <= 1'b0;
      data_q  <= 8'd0;
    end else begin
      pace_q  <= pace_d;
      oe_q    <= host_sel;
      valid_q <= pop;
      data_q  <= data_d;
    end
  end

  assign vid_data  = data_q;
  assign vid_valid = valid_q;
  assign vid_oe    = oe_q;

endmodule

// File: rtl/vid_pes_filter.sv
module vid_pes_filter
  import vpf_pkg::*;
#(
  parameter int PID_W = 13,
  parameter int DEPTH = 32,
  parameter int DIV   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       ts_data,
  input  logic             ts_valid,
  input  logic             ts_sync,
  input  logic [PID_W-1:0] cfg_pid,
  input  logic             cfg_es,
  input  logic             host_sel,
  input  logic             stamp_ack,
  output logic [7:0]       vid_data,
  output logic             vid_valid,
  output logic             vid_oe,
  output logic [32:0]      pts_val,
  output logic [32:0]      dts_val,
  output logic             stamp_has_dts,
  output logic             stamp_new
);

  logic [1:0] rs_q;
  logic       rst_s;
  logic       push, pes_vld, pop, q_empty, q_full;
  logic [7:0] push_data, pes_off, q_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  vpf_parse #(.PID_W(PID_W)) u_parse (
    .clk(clk), .rst_n(rst_s),
    .ts_data(ts_data), .ts_valid(ts_valid), .ts_sync(ts_sync),
    .cfg_pid(cfg_pid), .cfg_es(cfg_es),
    .push(push), .push_data(push_data),
    .pes_vld(pes_vld), .pes_off(pes_off)
  );

  vpf_stamp u_stamp (
    .clk(clk), .rst_n(rst_s),
    .pes_vld(pes_vld), .pes_off(pes_off), .pes_data(ts_data),
    .ack(stamp_ack),
    .pts(pts_val), .dts(dts_val),
    .has_dts(stamp_has_dts), .fresh(stamp_new)
  );

  vpf_fifo #(.W(8), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_s),
    .wr_en(push), .wr_data(push_data),
    .rd_en(pop), .rd_data(q_data),
    .empty(q_empty), .full(q_full)
  );

  vpf_drive #(.DIV(DIV)) u_drive (
    .clk(clk), .rst_n(rst_s),
    .host_sel(host_sel), .q_empty(q_empty), .q_data(q_data),
    .pop(pop), .vid_data(vid_data), .vid_valid(vid_valid), .vid_oe(vid_oe)
  );

endmodule

// File: rtl/vpf_chk.sv
module vpf_chk #(
  parameter int DIV = 3
) (
  input logic clk,
  input logic rst_n,
  input logic host_sel,
  input logic vid_valid,
  input logic vid_oe,
  input logic stamp_new,
  input logic stamp_ack,
  input logic stamp_has_dts
);

  int gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         gap_q <= DIV;
    else if (vid_valid) gap_q <= 0;
    else if (gap_q < DIV) gap_q <= gap_q + 1;
  end

  // R8
  pace_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vid_valid |-> (gap_q >= DIV - 1));

  // R9
  sel_low_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_sel |=> !vid_valid);

  // R10
  oe_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_sel |=> !vid_oe);

  // R10
  valid_needs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vid_valid |-> vid_oe);

  // R7
  flag_clear_by_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stamp_new) |-> $past(stamp_ack));

  // R6
  dts_flag_with_publish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stamp_has_dts) |-> stamp_new);

endmodule

bind vid_pes_filter vpf_chk #(.DIV(DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_sel(host_sel),
  .vid_valid(vid_valid), .vid_oe(vid_oe),
  .stamp_new(stamp_new), .stamp_ack(stamp_ack), .stamp_has_dts(stamp_has_dts)
);

// File: tb/sim_vid_pes_filter.sv
module sim_vid_pes_filter;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  ts_data;
  logic        ts_valid, ts_sync;
  logic [12:0] cfg_pid;
  logic        cfg_es, host_sel, stamp_ack;
  logic [7:0]  vid_data;
  logic        vid_valid, vid_oe;
  logic [32:0] pts_val, dts_val;
  logic        stamp_has_dts, stamp_new;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  logic sel_edge = 1'b0;
  bit   mon_on = 1'b0;
  bit   toggle_on = 1'b0;
  int   gap = 100;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  vid_pes_filter u0 (
    .clk(clk), .rst_n(rst_n), .ts_data(ts_data), .ts_valid(ts_valid), .ts_sync(ts_sync),
    .cfg_pid(cfg_pid), .cfg_es(cfg_es), .host_sel(host_sel), .stamp_ack(stamp_ack),
    .vid_data(vid_data), .vid_valid(vid_valid), .vid_oe(vid_oe),
    .pts_val(pts_val), .dts_val(dts_val), .stamp_has_dts(stamp_has_dts), .stamp_new(stamp_new)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) sel_edge <= host_sel;

  // per-clock comparison against the reference queue
  always @(negedge clk) begin
    if (mon_on) begin
      check(vid_oe === sel_edge, "R10", "oe vs select", {63'd0, vid_oe}, {63'd0, sel_edge});
      if (vid_valid) begin
        check(sel_edge === 1'b1, "R9", "byte while select low", 64'd1, 64'd0);
        check(gap >= 2, "R8", "byte spacing", 64'(gap), 64'd2);
        if (exp_q.size() == 0) begin
          check(1'b0, "R1", "unexpected byte", {56'd0, vid_data}, 64'd0);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(vid_data === e, "R3", "byte order/value", {56'd0, vid_data}, {56'd0, e});
        end
        gap = 0;
      end else if (gap < 100) begin
        gap++;
      end
    end
  end

  // select pattern: 43 cycles owned by block, 17 by host
  initial begin
    host_sel = 1'b1;
    wait (toggle_on);
    forever begin
      repeat (43) @(negedge clk);
      host_sel = 1'b0;
      repeat (17) @(negedge clk);
      host_sel = 1'b1;
    end
  end

  function automatic logic [7:0] sbyte(input logic [32:0] s, input int k, input logic [3:0] pfx);
    case (k)
      0:       return {pfx, s[32:30], 1'b1};
      1:       return s[29:22];
      2:       return {s[21:15], 1'b1};
      3:       return s[14:7];
      default: return {s[6:0], 1'b1};
    endcase
  endfunction

  task automatic send_pkt(input logic [12:0] pid, input bit pusi, input logic [1:0] afc,
                          input int aflen, input logic [1:0] flags, input int hlen,
                          input logic [32:0] pts, input logic [32:0] dts,
                          input logic [7:0] seed, input int len);
    logic [7:0] b [188];
    int ps;
    for (int i = 0; i < 188; i++) b[i] = seed + 8'(i * 7);
    b[0] = 8'h47;
    b[1] = {1'b0, pusi, 1'b0, pid[12:8]};
    b[2] = pid[7:0];
    b[3] = {2'b00, afc, 4'h3};
    if (afc == 2'b01) ps = 4;
    else if (afc == 2'b11) begin
      ps = 5 + aflen;
      b[4] = 8'(aflen);
      for (int i = 5; i < ps; i++) b[i] = 8'hFF;
    end else ps = 188;
    if (pusi && ps < 188) begin
      b[ps+0] = 8'h00; b[ps+1] = 8'h00; b[ps+2] = 8'h01; b[ps+3] = 8'hE0;
      b[ps+4] = 8'h00; b[ps+5] = 8'h00; b[ps+6] = 8'h80;
      b[ps+7] = {flags, 6'd0};
      b[ps+8] = 8'(hlen);
      for (int k = 0; k < hlen; k++) b[ps+9+k] = 8'hFF;
      if (flags[1]) for (int k = 0; k < 5; k++)
        b[ps+9+k] = sbyte(pts, k, flags[0] ? 4'b0011 : 4'b0010);
      if (flags == 2'b11) for (int k = 0; k < 5; k++)
        b[ps+14+k] = sbyte(dts, k, 4'b0001);
    end
    // reference: which bytes must come out (R1..R4)
    for (int i = ps; i < len; i++) begin
      if (pid == cfg_pid && !(cfg_es && pusi && (i - ps) < 9 + hlen))
        exp_q.push_back(b[i]);
    end
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      ts_valid = 1'b1; ts_data = b[i]; ts_sync = (i == 0);
      @(negedge clk);
      ts_valid = 1'b0; ts_sync = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic drain(input string req);
    int n = 0;
    while (exp_q.size() > 0 && n < 4000) begin
      @(negedge clk);
      n++;
    end
    repeat (80) @(negedge clk);
    check(exp_q.size() == 0, req, "bytes left undelivered", 64'(exp_q.size()), 64'd0);
  endtask

  task automatic chk_stamp(input string req, input bit en, input logic [32:0] ep,
                           input logic [32:0] ed, input bit eh);
    check(stamp_new === en, req, "stamp_new", {63'd0, stamp_new}, {63'd0, en});
    check(pts_val === ep, req, "pts", {31'd0, pts_val}, {31'd0, ep});
    if (eh) check(dts_val === ed, req, "dts", {31'd0, dts_val}, {31'd0, ed});
    check(stamp_has_dts === eh, req, "has_dts", {63'd0, stamp_has_dts}, {63'd0, eh});
  endtask

  task automatic do_ack();
    @(negedge clk); stamp_ack = 1'b1;
    @(negedge clk); stamp_ack = 1'b0;
    check(stamp_new === 1'b0, "R7", "flag after ack", {63'd0, stamp_new}, 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [32:0] p1, p2, d2, p3, p4, d4;
    p1 = 33'h1_2345_6789; p2 = 33'h0_ABCD_EF01; d2 = 33'h1_0000_0F0F;
    p3 = 33'h1_FFFF_FFFE; p4 = 33'h0_0000_0001; d4 = 33'h1_5555_AAAA;
    rst_n = 1'b0; ts_data = 8'd0; ts_valid = 1'b0; ts_sync = 1'b0;
    cfg_pid = 13'h1A5; cfg_es = 1'b0; stamp_ack = 1'b0;
    repeat (5) @(negedge clk);
    // R11 reset state
    check(vid_oe === 1'b0 && vid_valid === 1'b0, "R11", "bus idle in reset",
          {62'd0, vid_oe, vid_valid}, 64'd0);
    check(stamp_new === 1'b0 && pts_val === 33'd0 && dts_val === 33'd0, "R11", "stamps in reset",
          {31'd0, pts_val}, 64'd0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    mon_on = 1'b1;
    toggle_on = 1'b1;

    // R3 R5: PES mode, PTS only
    send_pkt(13'h1A5, 1, 2'b01, 0, 2'b10, 5, p1, 33'd0, 8'h10, 188);
    chk_stamp("R5", 1'b1, p1, 33'd0, 1'b0);
    do_ack();
    // R1: other identifier, carrying stamps that must be ignored
    send_pkt(13'h0A5, 1, 2'b01, 0, 2'b11, 10, p3, d4, 8'h20, 188);
    chk_stamp("R1", 1'b0, p1, 33'd0, 1'b0);
    // R2: adaptation field then payload, and adaptation only
    send_pkt(13'h1A5, 0, 2'b11, 7, 2'b00, 0, 33'd0, 33'd0, 8'h30, 188);
    send_pkt(13'h1A5, 0, 2'b10, 0, 2'b00, 0, 33'd0, 33'd0, 8'h40, 188);
    drain("R2");
    // R6: PTS and DTS together
    send_pkt(13'h1A5, 1, 2'b11, 3, 2'b11, 12, p2, d2, 8'h50, 188);
    chk_stamp("R6", 1'b1, p2, d2, 1'b1);
    drain("R3");

    // R4: elementary stream mode
    cfg_es = 1'b1;
    send_pkt(13'h1A5, 1, 2'b01, 0, 2'b10, 5, p3, 33'd0, 8'h60, 188);
    chk_stamp("R5", 1'b1, p3, 33'd0, 1'b0);
    do_ack();
    send_pkt(13'h1A5, 1, 2'b01, 0, 2'b11, 10, p4, d4, 8'h70, 188);
    chk_stamp("R6", 1'b1, p4, d4, 1'b1);
    do_ack();
    send_pkt(13'h1A5, 0, 2'b01, 0, 2'b00, 0, 33'd0, 33'd0, 8'h80, 188);
    drain("R4");

    // R12: truncated packet, then a fresh sync
    send_pkt(13'h1A5, 0, 2'b01, 0, 2'b00, 0, 33'd0, 33'd0, 8'h90, 50);
    send_pkt(13'h1A5, 0, 2'b11, 2, 2'b00, 0, 33'd0, 33'd0, 8'hA0, 188);
    drain("R12");
    // R9: no loss or repeat across all select pauses
    check(exp_q.size() == 0, "R9", "queue empty at end", 64'(exp_q.size()), 64'd0);
    chk_stamp("R7", 1'b0, p4, d4, 1'b1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule